// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block controls 28 general-purpose pins behind a simple 32-bit register bus. The bus has a read strobe, a write strobe, a word address and data. Each pin has a direction bit and an output latch. The output latch is changed only through two separate registers: one sets latch bits and the other clears them, and a zero bit written to either leaves the latch alone. The pad drivers appear as two vectors, an output value and an output enable.

Pad inputs pass through a two-flop synchronizer. The synchronized level is compared with its value one clock earlier. A rising change is recorded in a sticky status register when that pin's rise-enable bit is set, and a falling change is recorded when its fall-enable bit is set. Software clears status bits by writing ones to them. Pins 0 to 10 each drive their own interrupt line. Pins 11 to 27 share one line that is the OR of their status bits.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After the synchronous active-low reset, every register reads zero, all pins are inputs (pad_oe is zero), pad_out is zero and no interrupt line is high.
- R2: Word addresses select the registers: 0 level, 1 direction, 2 latch-set, 3 latch-clear, 4 rise-enable, 5 fall-enable, 6 edge status, 7 alternate-function storage. A read strobe loads bus_rdata at the next clock edge, and the value holds until the next read. Reading word 2 or word 3 returns zero.
- R3: The level register returns the synchronized pad value for input pins and the latch value for output pins. Writes to the level register change nothing.
- R4: Bit n of the direction register set to 1 makes pin n an output (pad_oe[n]=1), and set to 0 makes it an input. pad_out always equals the output latch.
- R5: Writing 1 to bit n of word 2 sets latch bit n, and writing 1 to bit n of word 3 clears it. Zero bits leave the latch unchanged.
- R6: A rising change on pin n sets status bit n only when rise-enable bit n is 1.
- R7: A falling change on pin n sets status bit n only when fall-enable bit n is 1. With both enable bits set, either change is caught.
- R8: While both enable registers are zero, no status bit becomes set, however the pins toggle.
- R9: Writing 1 to a status bit clears it, and writing all ones clears every pending bit. Zero bits leave status unchanged.
- R10: When a new edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R11: irq_pin[n] is high exactly while status bit n (n = 0..10) is set. irq_shared is high while any of status bits 11..27 is set.
- R12: Bits 31:28 of every register read as zero and ignore writes. The alternate-function register stores bits 27:0 and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 28 | Asynchronous pin levels |
| pad_out | output | 28 | Pad output values (latch) |
| pad_oe | output | 28 | Pad output enables (direction) |
| irq_pin | output | 11 | Dedicated interrupts for pins 0..10 |
| irq_shared | output | 1 | Shared interrupt for pins 11..27 |

## Verification
Some rules are checked on every cycle by assertions. These are: a set or clear write lands in the latch, a status bit cannot appear while both enables are zero, a clear with no coinciding edge leaves the bit at zero, a coinciding edge keeps the bit set, and the upper read bits stay zero. Other behaviour can only be shown by the bench's scenarios. This covers the synchronizer delay before an edge is recorded, the choice between latch value and pad value in the level register, the interrupt fan-out, and the exact cycle in which an edge and a clear collide. The bench checks all of these against a model of the pins it drives.

// File: rtl/gpio_edge_pkg.sv
// Shared definitions for the GPIO edge controller: register word selects.
// Assumes a word-addressed bus with eight register slots.
package gpio_edge_pkg;
    localparam int unsigned REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_LEVEL = 3'd0,
        REG_DIR   = 3'd1,
        REG_OSET  = 3'd2,
        REG_OCLR  = 3'd3,
        REG_RISE  = 3'd4,
        REG_FALL  = 3'd5,
        REG_STAT  = 3'd6,
        REG_ALT   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is independent; no multi-bit coherence is required.
module gpio_sync #(
    parameter int unsigned WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages between the pad and the core logic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
// Per-pin edge detector with a sticky, write-one-to-clear status register.
// Assumes pin_sync is already synchronized. A new edge beats a clear on the same bit.
module gpio_edge_detect #(
    parameter int unsigned WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] edge_hit
);
    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    // Qualify each pin's change by the matching polarity enable
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic rose, fell;
        always_comb begin
            rose        = pin_sync[i] & ~prev_q[i];
            fell        = ~pin_sync[i] & prev_q[i];
            edge_hit[i] = (rose & rise_en[i]) | (fell & fall_en[i]);
        end
    end

    // Sticky status: clear first, then set, so a new edge wins
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | edge_hit;
    end

    // R8
    no_enable_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_en == '0 && fall_en == '0) |=> ((status & ~$past(status)) == '0));

    // R9
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr_mask & ~edge_hit)) == '0));

    // R10
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(edge_hit)) == $past(edge_hit)));
endmodule

// File: rtl/gpio_irq_fanout.sv
// Splits the status vector into dedicated lines for the low pins and one shared OR line.
// Assumes NUM_DED is less than WIDTH.
module gpio_irq_fanout #(
    parameter int unsigned WIDTH   = 28,
    parameter int unsigned NUM_DED = 11
) (
    input  logic [WIDTH-1:0]   status,
    output logic [NUM_DED-1:0] irq_ded,
    output logic               irq_any_hi
);
    // One dedicated line per low pin
    for (genvar i = 0; i < NUM_DED; i++) begin : g_ded
        assign irq_ded[i] = status[i];
    end

    // OR of all remaining pins
    assign irq_any_hi = |status[WIDTH-1:NUM_DED];
endmodule

// File: rtl/gpio_edge_ctrl.sv
// GPIO controller top: register decode, output latch, direction, enables,
// alternate-function storage and registered read path.
// Assumes NUM_PINS < DATA_W and a single-cycle write strobe per access.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_PINS = 28,
    parameter int unsigned NUM_DED  = 11,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_DED-1:0]    irq_pin,
    output logic                  irq_shared
);
    localparam int unsigned PAD_W = DATA_W - NUM_PINS;

    logic [NUM_PINS-1:0] dir_q, latch_q, rise_q, fall_q, alt_q;
    logic [NUM_PINS-1:0] pin_sync, status, edge_hit, clr_mask, level;
    logic [NUM_PINS-1:0] wbits, rsel;
    logic                unused_wdata_hi;
    reg_sel_e            sel;

    assign sel             = reg_sel_e'(bus_addr);
    assign wbits           = bus_wdata[NUM_PINS-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // Status clear mask from a write to the status word
    assign clr_mask = (bus_wr && sel == REG_STAT) ? wbits : '0;

    gpio_edge_detect #(.WIDTH(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .clr_mask (clr_mask),
        .status   (status),
        .edge_hit (edge_hit)
    );

    gpio_irq_fanout #(.WIDTH(NUM_PINS), .NUM_DED(NUM_DED)) u_irq (
        .status     (status),
        .irq_ded    (irq_pin),
        .irq_any_hi (irq_shared)
    );

    // Configuration registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            alt_q   <= '0;
        end else if (bus_wr) begin
            case (sel)
                REG_DIR:  dir_q   <= wbits;
                REG_OSET: latch_q <= latch_q | wbits;
                REG_OCLR: latch_q <= latch_q & ~wbits;
                REG_RISE: rise_q  <= wbits;
                REG_FALL: fall_q  <= wbits;
                REG_ALT:  alt_q   <= wbits;
                default:  ;
            endcase
        end
    end

    // Pin level view: driven value for outputs, synchronized pad for inputs
    assign level = (dir_q & latch_q) | (~dir_q & pin_sync);

    // Read multiplexer
    always_comb begin
        case (sel)
            REG_LEVEL: rsel = level;
            REG_DIR:   rsel = dir_q;
            REG_RISE:  rsel = rise_q;
            REG_FALL:  rsel = fall_q;
            REG_STAT:  rsel = status;
            REG_ALT:   rsel = alt_q;
            default:   rsel = '0;
        endcase
    end

    // Registered read data, loaded on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= {{PAD_W{1'b0}}, rsel};
    end

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;

    // R5
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_OSET) |=> ((pad_out & $past(wbits)) == $past(wbits)));

    // R5
    latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_OCLR) |=> ((pad_out & $past(wbits)) == '0));

    // R12
    rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_PINS] == '0);
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb;
    localparam int NP = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
    logic [10:0] irq_pin;
    logic        irq_shared;

    int errors = 0, checks = 0;
    bit done = 0;

    // model state
    logic [NP-1:0] m_dir = '0, m_lat = '0, m_rise = '0, m_fall = '0, m_stat = '0, m_alt = '0;

    always #2.5 clk = ~clk;

    gpio_edge_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_pin(irq_pin), .irq_shared(irq_shared)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [NP-1:0] edges_of(input logic [NP-1:0] o, input logic [NP-1:0] n,
                                               input logic [NP-1:0] r, input logic [NP-1:0] f);
        return (~o & n & r) | (o & ~n & f);
    endfunction

    function automatic logic [NP-1:0] level_of(input logic [NP-1:0] pads);
        return (m_dir & m_lat) | (~m_dir & pads);
    endfunction

    // Change pads, let the synchronizer settle, update model
    task automatic drive_pads(input logic [NP-1:0] v);
        @(negedge clk);
        m_stat = m_stat | edges_of(pad_in, v, m_rise, m_fall);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_irq(input string req);
        chk(req, {21'd0, irq_pin}, {21'd0, m_stat[10:0]});
        chk(req, {31'd0, irq_shared}, {31'd0, |m_stat[NP-1:11]});
    endtask

    task automatic check_stat(input string req);
        logic [31:0] d;
        rd(3'd6, d);
        chk(req, d, {4'd0, m_stat});
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and output
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d);
            chk("R1", d, 32'd0);
        end
        chk("R1", {4'd0, pad_oe}, 32'd0);
        chk("R1", {4'd0, pad_out}, 32'd0);
        check_irq("R1");

        // R4/R5: direction and set/clear registers
        wr(3'd1, 32'h0000_00FF); m_dir = 28'h00000FF;
        chk("R4", {4'd0, pad_oe}, 32'h0000_00FF);
        wr(3'd2, 32'h0000_0F0F); m_lat = 28'h0000F0F;
        chk("R5", {4'd0, pad_out}, 32'h0000_0F0F);
        wr(3'd3, 32'h0000_0003); m_lat = m_lat & ~28'h3;
        chk("R5", {4'd0, pad_out}, {4'd0, m_lat});
        wr(3'd2, 32'h0);
        chk("R5", {4'd0, pad_out}, {4'd0, m_lat});
        rd(3'd2, d); chk("R2", d, 32'd0);
        rd(3'd3, d); chk("R2", d, 32'd0);

        // R3: level mixes latch and pads; level writes ignored
        drive_pads(28'hAAAAAAA);
        rd(3'd0, d); chk("R3", d, {4'd0, level_of(pad_in)});
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); chk("R3", d, {4'd0, level_of(pad_in)});
        chk("R3", {4'd0, pad_out}, {4'd0, m_lat});

        // R12: upper bits ignored, alt storage
        wr(3'd7, 32'hFABC_DEF1); m_alt = 28'hABCDEF1;
        rd(3'd7, d); chk("R12", d, 32'h0ABC_DEF1);
        wr(3'd1, 32'hF000_0000); m_dir = '0;
        rd(3'd1, d); chk("R12", d, 32'd0);

        // R8: no enables, pins toggle
        drive_pads(28'h5555555);
        drive_pads(28'h0000000);
        check_stat("R8"); check_irq("R8");

        // R6: rising only on pin 2 and pin 20
        wr(3'd4, 32'h0010_0004); m_rise = 28'h0100004;
        drive_pads(28'h0100004);
        check_stat("R6"); check_irq("R11");
        drive_pads(28'h0000000);
        check_stat("R6");
        wr(3'd6, 32'hFFFF_FFFF); m_stat = '0;
        check_stat("R9"); check_irq("R11");

        // R7: both enables on pin 3 catch both edges
        wr(3'd5, 32'h0000_0008); m_fall = 28'h8;
        wr(3'd4, 32'h0000_0008); m_rise = 28'h8;
        drive_pads(28'h8);
        check_stat("R7");
        wr(3'd6, 32'h8); m_stat = '0;
        drive_pads(28'h0);
        check_stat("R7");

        // R10: new edge on pin 3 coincides with clearing write
        drive_pads(28'h8);
        @(negedge clk); pad_in = 28'h0;
        @(negedge clk);
        wr(3'd6, 32'h8);
        repeat (3) @(negedge clk);
        check_stat("R10");   // bit stays set
        wr(3'd6, 32'h8); m_stat = '0;
        check_stat("R9");

        // Random phase
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0, 1: drive_pads(NP'($urandom));
                2: begin d = $urandom; wr(3'd4, d); m_rise = d[NP-1:0]; end
                3: begin d = $urandom; wr(3'd5, d); m_fall = d[NP-1:0]; end
                4: begin d = $urandom; wr(3'd6, d); m_stat = m_stat & ~d[NP-1:0]; end
                default: begin
                    d = $urandom; wr(3'd1, d); m_dir = d[NP-1:0];
                    rd(3'd0, d); chk("R3", d, {4'd0, level_of(pad_in)});
                end
            endcase
            check_stat("R6"); check_irq("R11");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule